// File: doc/BRIEF.md
# Clock-Lane Character Pattern Generator

This block produces the 10-bit parallel character that a serializer sends on the clock lane of a serial video link, one character per character clock. The waveform is defined by software as four 10-bit slots. The block plays the slots back in a fixed cycle, so the same hardware can produce the usual divide-by-10 clock (five ones, then five zeros, in every character) or a divide-by-40 clock (two all-zero characters, then two all-one characters) for high character rates.

Software writes two staging words, each holding two slots. A control command then copies the staged slots into the active set and parks the output on slot 0. A second command starts playback. Because of this two-step sequence, the clock-lane waveform can be swapped between the two rates without a partial or mixed pattern ever appearing on the lane. Serialization and the physical layer sit outside this block.

Top module: `clkPatternGen`

## Requirements
- R1: After reset, every slot holds 0x01f in both the staging and active copies and playback runs, so `charOut` is 0x01f on every cycle, including while reset is asserted.
- R2: Address 0 stages slot 0 from bits 9:0 and slot 1 from bits 25:16. Address 1 stages slot 2 from bits 9:0 and slot 3 from bits 25:16. All other data bits are ignored.
- R3: While running, `charOut` shows slot 0, 1, 2, 3 in that order and then wraps, advancing one slot per clock.
- R4: A write to address 0 or 1 changes only the staging copy. `charOut` is unaffected until a load command.
- R5: A write of exactly 1 to address 2 (load) copies all staged slots into the active set, sets the slot index to 0 and pauses playback. From the next cycle, `charOut` shows the new slot 0 and holds it.
- R6: A write of exactly 2 to address 2 (run) resumes playback. The output shows the current slot for one more cycle and then advances. A run command while already running has no effect.
- R7: Any other value written to address 2 has no effect.
- R8: A load command issued while running takes effect in the same way as when paused: the index is forced to 0 and playback pauses.
- R9: Writes to address 3 have no effect.
- R10: Staging 0x00000000 at address 0 and 0x03ff03ff at address 1, then issuing load and run, produces the repeating sequence 0x000, 0x000, 0x3ff, 0x3ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register index: 0 and 1 are staging words, 2 is control |
| wrData | input | 32 | Write data |
| charOut | output | 10 | Clock-lane character for the current slot |

## Verification
Three waveforms are played. The first is the divide-by-10 default. The second is an asymmetric test pattern with four distinct, non-symmetric slot values (0x155, 0x2AA, 0x033, 0x3C0). The third is the divide-by-40 setting. The asymmetric pattern is the only one that shows the slot order, the wrap point and a swapped half-word; the two symmetric clock patterns would hide those faults. A staging word that has only the bits outside the slot fields set shows whether those bits are masked. The bench also checks load while running, load while paused, repeated run, unlisted control values and the unused address, and confirms that none of these disturb the output in ways the requirements do not allow.

// File: rtl/clkPatternPkg.sv
package clkPatternPkg;
  // Control command codes written to the control address
  localparam int CMD_LOAD = 1;
  localparam int CMD_RUN  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic stage;    // write a staging word
    logic load;     // copy staging to active, index to 0
    logic advance;  // step the slot index
  } patStrobe_t;
endpackage

// File: rtl/clkPatternCtrl.sv
module clkPatternCtrl
  import clkPatternPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int REG_CNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output patStrobe_t        strobes,
  output logic              running
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(REG_CNT);

  logic isCtrl;
  logic loadCmd;
  logic runCmd;

  always_comb begin
    isCtrl  = wrEn && (wrAddr == CTRL_ADDR);
    loadCmd = isCtrl && (wrData == DATA_W'(CMD_LOAD));
    runCmd  = isCtrl && (wrData == DATA_W'(CMD_RUN));
    strobes.stage   = wrEn && (int'(wrAddr) < REG_CNT);
    strobes.load    = loadCmd;
    strobes.advance = running && !loadCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b1;
    end else if (loadCmd) begin
      running <= 1'b0;
    end else if (runCmd) begin
      running <= 1'b1;
    end
  end
endmodule

// File: rtl/clkPatternData.sv
module clkPatternData
  import clkPatternPkg::*;
#(
  parameter int          CHAR_W     = 10,
  parameter int          SLOTS      = 4,
  parameter int          STG_IDX_W  = 1,
  parameter int          SLOT_IDX_W = 2,
  parameter logic [31:0] RESET_WORD = 32'h001f001f,
  parameter int          HI_LSB     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  patStrobe_t            strobes,
  input  logic [STG_IDX_W-1:0]  stageIdx,
  input  logic [CHAR_W-1:0]     loField,
  input  logic [CHAR_W-1:0]     hiField,
  output logic [SLOT_IDX_W-1:0] slotIdx,
  output logic [CHAR_W-1:0]     charOut
);
  localparam int REG_CNT = SLOTS / 2;
  localparam logic [CHAR_W-1:0] RESET_LO = RESET_WORD[CHAR_W-1:0];
  localparam logic [CHAR_W-1:0] RESET_HI = RESET_WORD[HI_LSB +: CHAR_W];
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(SLOTS - 1);

  logic [CHAR_W-1:0] stageSlots  [SLOTS];
  logic [CHAR_W-1:0] activeSlots [SLOTS];

  for (genvar r = 0; r < REG_CNT; r++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageSlots[2*r]   <= RESET_LO;
        stageSlots[2*r+1] <= RESET_HI;
      end else if (strobes.stage && (int'(stageIdx) == r)) begin
        stageSlots[2*r]   <= loField;
        stageSlots[2*r+1] <= hiField;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_active
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeSlots[s] <= (s % 2 == 0) ? RESET_LO : RESET_HI;
      end else if (strobes.load) begin
        activeSlots[s] <= stageSlots[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
    end else if (strobes.load) begin
      slotIdx <= '0;
    end else if (strobes.advance) begin
      slotIdx <= (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
    end
  end

  assign charOut = activeSlots[slotIdx];
endmodule

// File: rtl/clkPatternGen.sv
module clkPatternGen
  import clkPatternPkg::*;
#(
  parameter int          CHAR_W     = 10,
  parameter int          SLOTS      = 4,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 2,
  parameter int          HI_LSB     = 16,
  parameter logic [31:0] RESET_WORD = 32'h001f001f
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHAR_W-1:0] charOut
);
  localparam int REG_CNT    = SLOTS / 2;
  localparam int STG_IDX_W  = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
  localparam int SLOT_IDX_W = $clog2(SLOTS);

  patStrobe_t            strobes;
  logic                  running;
  logic [SLOT_IDX_W-1:0] slotIdx;

  clkPatternCtrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_CNT(REG_CNT)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobes(strobes),
    .running(running)
  );

  clkPatternData #(
    .CHAR_W    (CHAR_W),
    .SLOTS     (SLOTS),
    .STG_IDX_W (STG_IDX_W),
    .SLOT_IDX_W(SLOT_IDX_W),
    .RESET_WORD(RESET_WORD),
    .HI_LSB    (HI_LSB)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .stageIdx(wrAddr[STG_IDX_W-1:0]),
    .loField (wrData[CHAR_W-1:0]),
    .hiField (wrData[HI_LSB +: CHAR_W]),
    .slotIdx (slotIdx),
    .charOut (charOut)
  );
endmodule

// File: rtl/clkPatternGen_chk.sv
module clkPatternGen_chk #(
  parameter int CHAR_W     = 10,
  parameter int SLOTS      = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int SLOT_IDX_W = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [DATA_W-1:0]     wrData,
  input logic [CHAR_W-1:0]     charOut,
  input logic                  running,
  input logic [SLOT_IDX_W-1:0] slotIdx
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(SLOTS / 2);
  localparam logic [SLOT_IDX_W-1:0] LAST = SLOT_IDX_W'(SLOTS - 1);

  logic loadWr;
  logic runWr;
  logic otherWr;
  assign loadWr  = wrEn && wrAddr == CTRL_A && wrData == DATA_W'(1);
  assign runWr   = wrEn && wrAddr == CTRL_A && wrData == DATA_W'(2);
  assign otherWr = wrEn && wrAddr == CTRL_A && !loadWr && !runWr;

  p_load_parks_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> (slotIdx == '0) && !running);

  p_run_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    runWr |=> running);

  p_slot_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !loadWr) |=>
      (slotIdx == (($past(slotIdx) == LAST) ? '0 : $past(slotIdx) + 1'b1)));

  p_paused_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !loadWr) |=> $stable(charOut));

  p_other_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    otherWr |=> $stable(running));
endmodule

bind clkPatternGen clkPatternGen_chk #(
  .CHAR_W    (CHAR_W),
  .SLOTS     (SLOTS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SLOT_IDX_W(SLOT_IDX_W)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .charOut(charOut),
  .running(running),
  .slotIdx(slotIdx)
);

// File: tb/test_clkPatternGen.sv
module test_clkPatternGen;
  localparam time PERIOD = 4ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [9:0]  charOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkPatternGen i_clkPatternGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .charOut(charOut)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  a;
    logic [31:0] d;
    logic [9:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  // Each entry: inputs for one cycle, expected charOut after that edge
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h00000000, 10'h01f, 8'd1},  // R1 default runs
    '{1'b1, 2'd0, 32'h02AA0155, 10'h01f, 8'd4},  // R4 stage only
    '{1'b1, 2'd1, 32'h03C00033, 10'h01f, 8'd4},  // R4
    '{1'b1, 2'd2, 32'h00000001, 10'h155, 8'd5},  // R5 load
    '{1'b0, 2'd0, 32'h00000000, 10'h155, 8'd5},  // R5 hold
    '{1'b0, 2'd0, 32'h00000000, 10'h155, 8'd5},
    '{1'b1, 2'd2, 32'h00000002, 10'h155, 8'd6},  // R6 run
    '{1'b0, 2'd0, 32'h00000000, 10'h2AA, 8'd3},  // R3 slot1
    '{1'b0, 2'd0, 32'h00000000, 10'h033, 8'd2},  // R2 slot2
    '{1'b0, 2'd0, 32'h00000000, 10'h3C0, 8'd2},  // R2 slot3
    '{1'b0, 2'd0, 32'h00000000, 10'h155, 8'd3},  // R3 wrap
    '{1'b1, 2'd2, 32'h00000003, 10'h2AA, 8'd7},  // R7
    '{1'b1, 2'd2, 32'h00000000, 10'h033, 8'd7},  // R7
    '{1'b1, 2'd3, 32'h00000001, 10'h3C0, 8'd9},  // R9
    '{1'b1, 2'd0, 32'hFC00FC00, 10'h155, 8'd4},  // R4 stage masked
    '{1'b1, 2'd2, 32'h00000001, 10'h000, 8'd2},  // R2 outside bits ignored
    '{1'b0, 2'd0, 32'h00000000, 10'h000, 8'd5},
    '{1'b1, 2'd2, 32'h00000002, 10'h000, 8'd6},
    '{1'b0, 2'd0, 32'h00000000, 10'h000, 8'd3},
    '{1'b0, 2'd0, 32'h00000000, 10'h033, 8'd3},
    '{1'b1, 2'd1, 32'h03ff03ff, 10'h3C0, 8'd4},  // R4
    '{1'b1, 2'd2, 32'h00000001, 10'h000, 8'd8},  // R8 load while running
    '{1'b1, 2'd2, 32'h00000002, 10'h000, 8'd10}, // R10
    '{1'b0, 2'd0, 32'h00000000, 10'h000, 8'd10},
    '{1'b0, 2'd0, 32'h00000000, 10'h3ff, 8'd10},
    '{1'b0, 2'd0, 32'h00000000, 10'h3ff, 8'd10},
    '{1'b0, 2'd0, 32'h00000000, 10'h000, 8'd10},
    '{1'b1, 2'd2, 32'h00000002, 10'h000, 8'd6},  // R6 run while running
    '{1'b0, 2'd0, 32'h00000000, 10'h3ff, 8'd6}
  };

  task automatic check(input int req, input logic [9:0] exp);
    checks++;
    if (charOut !== exp) begin
      errors++;
      $display("FAIL R%0d: charOut %h expected %h", req, charOut, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d);
    wrEn = we; wrAddr = a; wrData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 10'h01f);                       // R1 during reset
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].a, VECS[i].d);
      @(negedge clk);
      check(int'(VECS[i].req), VECS[i].exp);
    end
    drive(1'b0, 2'd0, 32'h0);
    // Directed: reset mid-run restores defaults (R1)
    rstN = 1'b0;
    #1 check(1, 10'h01f);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 10'h01f);
    drive(1'b1, 2'd2, 32'h1);                // load staged defaults
    @(negedge clk);
    check(1, 10'h01f);
    drive(1'b1, 2'd2, 32'h2);
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0);
    @(negedge clk);
    check(1, 10'h01f);
    // R7: run code with upper bits set is not a command
    drive(1'b1, 2'd2, 32'h00010001);
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0);
    @(negedge clk);
    check(7, 10'h01f);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R0: watchdog expired, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule